// File: doc/BRIEF.md
# Shared-Period Eight-Channel PWM Timer

This block is a pulse-width modulation timer. One 16-bit up-counter sets the period for eight output channels. Each channel compares the shared count with its own threshold, so all channels share one period and each has its own duty. The counter does not run from the block clock directly. It advances on one of three clock-enable inputs (system, fixed or external), chosen by a control field. That enable is then divided by a power-of-two prescaler.

Software drives the timer through a plain register port with word-aligned addresses. A write takes effect on the clock edge, and a read returns the register at the read address in the same cycle. The period limit and each channel threshold are double-buffered. A new value is written into a holding copy, and the counter and comparators move to it only at a period boundary. A change therefore never cuts a pulse short or adds an extra one. Each channel also has a polarity-inversion bit and a mask bit. A masked channel drives its idle level.

Top module: `pwmt_top`

## Requirements
- R1: After reset, every register reads zero except the period limit (offset 0x08), which reads 0xFFFF, and the mask (offset 0x60), which reads 0xFF. The count is 0 and every PWM output is low.
- R2: Control bits [4:3] at offset 0x00 choose the enable input that clocks the counter: 1 selects tick_sys, 2 selects tick_fix and 3 selects tick_ext. With the value 0, or when the chosen enable stays low, the count holds.
- R3: Control bits [2:0] hold a prescale exponent P. The counter advances once every 2^P pulses of the chosen enable. A write to the control register restarts the prescale phase.
- R4: The count runs from the initial value (offset 0x4C) up to the active period limit. The step after it reaches the limit reloads the initial value.
- R5: A read at offset 0x04 returns the live count. A write at offset 0x04 loads the initial value into the counter and restarts the prescale phase.
- R6: Channel n has a control word at 0x0C+8n and a threshold at 0x10+8n. When control bits 5 and 3 are both set, the unmasked, non-inverted output is high while the count is below the active threshold. In any other mode the raw output is low.
- R7: An active threshold of 0 gives a constant idle output. An active threshold above the active period limit gives a constant high raw output.
- R8: Bit n of the polarity register (offset 0x70) inverts channel n's output.
- R9: When bit n of the mask register (offset 0x60) is set, channel n drives its polarity bit and the compare result is ignored.
- R10: Writes to the period limit and to the thresholds go into holding copies. The counter and comparators take up those copies only on a wrap step, a count write, or any cycle in which the clock field is 0.
- R11: Read-back: control returns bits [4:0]. The period limit, initial value and thresholds return their holding copies in bits [15:0]. Channel control returns bits [5:2]. Output-init (0x5C), mask and polarity return bits [7:0]. Every other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_sys | input | 1 | System counter-clock enable |
| tick_fix | input | 1 | Fixed counter-clock enable |
| tick_ext | input | 1 | External counter-clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte address (word aligned) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read byte address (word aligned) |
| rd_data | output | 32 | Read data for rd_addr |
| pwm_out | output | 8 | Channel outputs, bit n is channel n |

## Verification
Some behaviour is checked by the assertions on every cycle: a stopped counter holds its value, a wrap reloads the initial value, a count write restarts the counter, and the prescale phase never passes its limit. They also check that the active limit and thresholds change only on a load, and that masked outputs sit at their polarity level. Other behaviour only the bench scenarios can show. These are the duty of each channel against a reference count over many periods, the delay of buffered updates seen at the ports, the choice among the three enables, and register read-back.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

  // Byte offsets of the register map
  localparam int unsigned ADR_CTRL    = 32'h00;
  localparam int unsigned ADR_COUNT   = 32'h04;
  localparam int unsigned ADR_LIMIT   = 32'h08;
  localparam int unsigned ADR_CH_BASE = 32'h0C;
  localparam int unsigned CH_STRIDE   = 8;
  localparam int unsigned ADR_START   = 32'h4C;
  localparam int unsigned ADR_OINIT   = 32'h5C;
  localparam int unsigned ADR_MASK    = 32'h60;
  localparam int unsigned ADR_INVERT  = 32'h70;

  typedef enum logic [1:0] {
    SRC_OFF = 2'd0,
    SRC_SYS = 2'd1,
    SRC_FIX = 2'd2,
    SRC_EXT = 2'd3
  } src_e;

endpackage

// File: rtl/pwmt_regs.sv
module pwmt_regs
  import pwmt_pkg::*;
#(
  parameter int unsigned CW  = 16,
  parameter int unsigned NCH = 8,
  parameter int unsigned AW  = 8,
  parameter int unsigned DW  = 32,
  parameter int unsigned PSW = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [DW-1:0]           wr_data,
  input  logic [AW-1:0]           rd_addr,
  output logic [DW-1:0]           rd_data,
  input  logic [CW-1:0]           cnt,
  output logic [PSW-1:0]          ps,
  output src_e                    src,
  output logic                    ctrl_wr,
  output logic                    cnt_wr,
  output logic [CW-1:0]           cntin,
  output logic [CW-1:0]           mod_buf,
  output logic [NCH-1:0][CW-1:0]  cv_buf,
  output logic [NCH-1:0]          chmode,
  output logic [NCH-1:0]          mask,
  output logic [NCH-1:0]          pol
);

  localparam int unsigned IW     = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int unsigned CTW    = PSW + 2;
  localparam int unsigned OIW    = 8;
  localparam int unsigned CH_END = ADR_CH_BASE + CH_STRIDE * NCH;

  logic [AW-1:0]  wa, ra, w_off, r_off;
  logic           w_lim, w_start, w_oinit, w_mask, w_inv, w_chhit, w_iscv;
  logic [IW-1:0]  w_idx, r_idx;
  logic           r_chhit;

  logic [CTW-1:0] ctrl_q, ctrl_nxt;
  logic [CW-1:0]  lim_q, lim_nxt, start_q, start_nxt;
  logic [OIW-1:0] oinit_q, oinit_nxt;
  logic [NCH-1:0] mask_q, mask_nxt, inv_q, inv_nxt;
  logic [NCH-1:0][3:0] ctl_all;

  logic unused_bits;
  assign unused_bits = ^{wr_addr[1:0], rd_addr[1:0], wr_data};

  // ---------------- write decode ----------------
  always_comb begin
    wa      = {wr_addr[AW-1:2], 2'b00};
    ctrl_wr = wr_en && (wa == AW'(ADR_CTRL));
    cnt_wr  = wr_en && (wa == AW'(ADR_COUNT));
    w_lim   = wr_en && (wa == AW'(ADR_LIMIT));
    w_start = wr_en && (wa == AW'(ADR_START));
    w_oinit = wr_en && (wa == AW'(ADR_OINIT));
    w_mask  = wr_en && (wa == AW'(ADR_MASK));
    w_inv   = wr_en && (wa == AW'(ADR_INVERT));
    w_chhit = wr_en && (wa >= AW'(ADR_CH_BASE)) && (wa < AW'(CH_END));
    w_off   = wa - AW'(ADR_CH_BASE);
    w_idx   = w_off[IW+2:3];
    w_iscv  = w_off[2];
  end

  // ---------------- shared registers: next state ----------------
  always_comb begin
    ctrl_nxt  = ctrl_wr ? wr_data[CTW-1:0] : ctrl_q;
    lim_nxt   = w_lim   ? wr_data[CW-1:0]  : lim_q;
    start_nxt = w_start ? wr_data[CW-1:0]  : start_q;
    oinit_nxt = w_oinit ? wr_data[OIW-1:0] : oinit_q;
    mask_nxt  = w_mask  ? wr_data[NCH-1:0] : mask_q;
    inv_nxt   = w_inv   ? wr_data[NCH-1:0] : inv_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      lim_q   <= '1;
      start_q <= '0;
      oinit_q <= '0;
      mask_q  <= '1;
      inv_q   <= '0;
    end else begin
      ctrl_q  <= ctrl_nxt;
      lim_q   <= lim_nxt;
      start_q <= start_nxt;
      oinit_q <= oinit_nxt;
      mask_q  <= mask_nxt;
      inv_q   <= inv_nxt;
    end
  end

  // ---------------- per-channel holding registers ----------------
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [3:0]    ctl_q, ctl_nxt;
    logic [CW-1:0] cv_q, cv_nxt;
    logic          sel_me;

    always_comb begin
      sel_me  = w_chhit && (w_idx == IW'(g));
      ctl_nxt = (sel_me && !w_iscv) ? wr_data[5:2]     : ctl_q;
      cv_nxt  = (sel_me &&  w_iscv) ? wr_data[CW-1:0]  : cv_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctl_q <= '0;
        cv_q  <= '0;
      end else begin
        ctl_q <= ctl_nxt;
        cv_q  <= cv_nxt;
      end
    end

    assign ctl_all[g] = ctl_q;
    assign cv_buf[g]  = cv_q;
    assign chmode[g]  = ctl_q[3] & ctl_q[1];
  end

  // ---------------- read mux ----------------
  always_comb begin
    ra      = {rd_addr[AW-1:2], 2'b00};
    r_chhit = (ra >= AW'(ADR_CH_BASE)) && (ra < AW'(CH_END));
    r_off   = ra - AW'(ADR_CH_BASE);
    r_idx   = r_off[IW+2:3];
    rd_data = '0;
    if (r_chhit) begin
      if (r_off[2]) rd_data = DW'(cv_buf[r_idx]);
      else          rd_data = DW'({ctl_all[r_idx], 2'b00});
    end else if (ra == AW'(ADR_CTRL))   rd_data = DW'(ctrl_q);
    else if (ra == AW'(ADR_COUNT))      rd_data = DW'(cnt);
    else if (ra == AW'(ADR_LIMIT))      rd_data = DW'(lim_q);
    else if (ra == AW'(ADR_START))      rd_data = DW'(start_q);
    else if (ra == AW'(ADR_OINIT))      rd_data = DW'(oinit_q);
    else if (ra == AW'(ADR_MASK))       rd_data = DW'(mask_q);
    else if (ra == AW'(ADR_INVERT))     rd_data = DW'(inv_q);
  end

  assign ps      = ctrl_q[PSW-1:0];
  assign src     = src_e'(ctrl_q[PSW+1:PSW]);
  assign cntin   = start_q;
  assign mod_buf = lim_q;
  assign mask    = mask_q;
  assign pol     = inv_q;

  AST_ONE_WRITE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ctrl_wr, cnt_wr, w_lim, w_start, w_oinit, w_mask, w_inv, w_chhit}) <= 1); // R11

endmodule

// File: rtl/pwmt_counter.sv
module pwmt_counter
  import pwmt_pkg::*;
#(
  parameter int unsigned CW  = 16,
  parameter int unsigned PSW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  src_e           src,
  input  logic [PSW-1:0] ps,
  input  logic           ctrl_wr,
  input  logic           cnt_wr,
  input  logic           tick_sys,
  input  logic           tick_fix,
  input  logic           tick_ext,
  input  logic [CW-1:0]  cntin,
  input  logic [CW-1:0]  mod_buf,
  output logic [CW-1:0]  cnt,
  output logic           load
);

  localparam int unsigned PRW = (1 << PSW) - 1;

  logic [PRW-1:0] pre_q, pre_nxt, lim;
  logic [CW-1:0]  cnt_q, cnt_nxt, mod_q, mod_nxt;
  logic           sel, step, wrap;

  always_comb begin
    unique case (src)
      SRC_SYS: sel = tick_sys;
      SRC_FIX: sel = tick_fix;
      SRC_EXT: sel = tick_ext;
      default: sel = 1'b0;
    endcase
    lim  = PRW'((32'd1 << ps) - 32'd1);
    step = sel && !cnt_wr && (pre_q == lim);
    wrap = step && (cnt_q == mod_q);
    load = wrap || cnt_wr || (src == SRC_OFF);

    if (cnt_wr || ctrl_wr)  pre_nxt = '0;
    else if (sel)           pre_nxt = (pre_q == lim) ? '0 : pre_q + PRW'(1);
    else                    pre_nxt = pre_q;

    if (cnt_wr || wrap)     cnt_nxt = cntin;
    else if (step)          cnt_nxt = cnt_q + CW'(1);
    else                    cnt_nxt = cnt_q;

    mod_nxt = load ? mod_buf : mod_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
      mod_q <= '1;
    end else begin
      pre_q <= pre_nxt;
      cnt_q <= cnt_nxt;
      mod_q <= mod_nxt;
    end
  end

  assign cnt = cnt_q;

  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_OFF && !cnt_wr) |=> $stable(cnt_q)); // R2
  AST_PRE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= lim); // R3
  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == $past(cntin))); // R4
  AST_COUNT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt_q == $past(cntin) && pre_q == '0)); // R5
  AST_LIMIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(mod_q)); // R10

endmodule

// File: rtl/pwmt_channel.sv
module pwmt_channel #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] cv_buf,
  input  logic [CW-1:0] cnt,
  input  logic          mode,
  input  logic          mask,
  input  logic          pol,
  output logic          pwm
);

  logic [CW-1:0] cv_q, cv_nxt;
  logic          raw;

  always_comb begin
    cv_nxt = load ? cv_buf : cv_q;
    raw    = mode && (cnt < cv_q);
    pwm    = pol ^ (raw && !mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cv_q <= '0;
    else        cv_q <= cv_nxt;
  end

  AST_THRESH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cv_q)); // R10
  AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
    (cv_q == '0) |-> (pwm == pol)); // R7

endmodule

// File: rtl/pwmt_top.sv
module pwmt_top
  import pwmt_pkg::*;
#(
  parameter int unsigned CW  = 16,
  parameter int unsigned NCH = 8,
  parameter int unsigned AW  = 8,
  parameter int unsigned DW  = 32,
  parameter int unsigned PSW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_sys,
  input  logic           tick_fix,
  input  logic           tick_ext,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic [AW-1:0]  rd_addr,
  output logic [DW-1:0]  rd_data,
  output logic [NCH-1:0] pwm_out
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [PSW-1:0]         ps;
  src_e                   src;
  logic                   ctrl_wr, cnt_wr, load;
  logic [CW-1:0]          cntin, mod_buf, cnt;
  logic [NCH-1:0][CW-1:0] cv_buf;
  logic [NCH-1:0]         chmode, mask, pol;

  pwmt_regs #(.CW(CW), .NCH(NCH), .AW(AW), .DW(DW), .PSW(PSW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .cnt     (cnt),
    .ps      (ps),
    .src     (src),
    .ctrl_wr (ctrl_wr),
    .cnt_wr  (cnt_wr),
    .cntin   (cntin),
    .mod_buf (mod_buf),
    .cv_buf  (cv_buf),
    .chmode  (chmode),
    .mask    (mask),
    .pol     (pol)
  );

  pwmt_counter #(.CW(CW), .PSW(PSW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .src      (src),
    .ps       (ps),
    .ctrl_wr  (ctrl_wr),
    .cnt_wr   (cnt_wr),
    .tick_sys (tick_sys),
    .tick_fix (tick_fix),
    .tick_ext (tick_ext),
    .cntin    (cntin),
    .mod_buf  (mod_buf),
    .cnt      (cnt),
    .load     (load)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_out
    pwmt_channel #(.CW(CW)) u_ch (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .load   (load),
      .cv_buf (cv_buf[g]),
      .cnt    (cnt),
      .mode   (chmode[g]),
      .mask   (mask[g]),
      .pol    (pol[g]),
      .pwm    (pwm_out[g])
    );
  end

  AST_MASK_LEVEL: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((pwm_out ^ pol) & mask) == '0); // R9
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_int_n |-> (pwm_out == '0)); // R1

endmodule

// File: tb/sim_pwmt_top.sv
`timescale 1ns/1ps
module sim_pwmt_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_sys = 1'b0, tick_fix = 1'b0, tick_ext = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [7:0]  pwm_out;

  always #4 clk = ~clk;

  pwmt_top u0 (
    .clk(clk), .rst_n(rst_n), .tick_sys(tick_sys), .tick_fix(tick_fix),
    .tick_ext(tick_ext), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pwm_out(pwm_out)
  );

  int n_run = 0, n_fail = 0, wd = 0;

  // reference state, built from the requirements
  logic [2:0]  m_ps;
  logic [1:0]  m_src;
  logic [6:0]  m_pre;
  logic [15:0] m_cnt, m_lim_buf, m_lim_act, m_start;
  logic [15:0] m_cv_buf [8];
  logic [15:0] m_cv_act [8];
  logic [3:0]  m_ctl [8];
  logic [7:0]  m_oinit, m_mask, m_inv;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ps = 0; m_src = 0; m_pre = 0; m_cnt = 0;
      m_lim_buf = 16'hFFFF; m_lim_act = 16'hFFFF; m_start = 0;
      m_oinit = 0; m_mask = 8'hFF; m_inv = 0;
      for (int i = 0; i < 8; i++) begin m_cv_buf[i] = 0; m_cv_act[i] = 0; m_ctl[i] = 0; end
    end else begin
      logic sel, step, wrap, ld, cw, tw;
      logic [6:0] lim;
      sel = (m_src == 1 && tick_sys) || (m_src == 2 && tick_fix) || (m_src == 3 && tick_ext);
      lim = 7'((8'd1 << m_ps) - 8'd1);
      cw  = wr_en && wr_addr == 8'h04;
      tw  = wr_en && wr_addr == 8'h00;
      step = 0;
      if (cw) m_pre = 0;
      else if (sel) begin
        if (m_pre == lim) begin m_pre = 0; step = 1; end
        else m_pre = m_pre + 1;
      end
      if (tw) m_pre = 0;
      wrap = step && (m_cnt == m_lim_act);
      ld   = wrap || cw || (m_src == 0);
      if (cw || wrap) m_cnt = m_start;
      else if (step)  m_cnt = m_cnt + 1;
      if (ld) begin
        m_lim_act = m_lim_buf;
        for (int i = 0; i < 8; i++) m_cv_act[i] = m_cv_buf[i];
      end
      if (wr_en) begin
        case (wr_addr)
          8'h00: begin m_ps = wr_data[2:0]; m_src = wr_data[4:3]; end
          8'h08: m_lim_buf = wr_data[15:0];
          8'h4C: m_start = wr_data[15:0];
          8'h5C: m_oinit = wr_data[7:0];
          8'h60: m_mask = wr_data[7:0];
          8'h70: m_inv = wr_data[7:0];
          default: if (wr_addr >= 8'h0C && wr_addr < 8'h4C) begin
            int k;
            k = (int'(wr_addr) - 12) / 8;
            if (((int'(wr_addr) - 12) % 8) == 4) m_cv_buf[k] = wr_data[15:0];
            else m_ctl[k] = wr_data[5:2];
          end
        endcase
      end
    end
  end

  function automatic logic exp_bit(int n);
    logic raw;
    raw = m_ctl[n][3] && m_ctl[n][1] && (m_cnt < m_cv_act[n]);
    return m_mask[n] ? m_inv[n] : (m_inv[n] ^ raw);
  endfunction

  function automatic string tag_of(int n);
    if (m_mask[n]) return "R9 masked";
    if (m_inv[n]) return "R8 inverted";
    if (m_cv_act[n] == 0 || m_cv_act[n] > m_lim_act) return "R7 edge duty";
    return "R6 compare";
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(string tag, logic [7:0] a, logic [31:0] exp);
    rd_addr = a;
    #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic check_now();
    for (int n = 0; n < 8; n++) chk(tag_of(n), 32'(pwm_out[n]), 32'(exp_bit(n)));
    rd("R4 count", 8'h04, 32'(m_cnt));
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    check_now();
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    step();
    wr_en = 0;
  endtask

  task automatic ticks(logic s, logic f, logic e);
    tick_sys = s; tick_fix = f; tick_ext = e;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<150000", wd);
      summary();
    end
  end

  initial begin
    logic [15:0] held;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 outputs", 32'(pwm_out), 32'h0);
    rd("R1 ctrl", 8'h00, 0);
    rd("R1 limit", 8'h08, 32'hFFFF);
    rd("R1 mask", 8'h60, 32'hFF);
    rd("R1 invert", 8'h70, 0);
    rd("R1 oinit", 8'h5C, 0);
    rd("R1 count", 8'h04, 0);
    rst_n = 1;
    repeat (4) step();

    // R11 read-back
    wr(8'h5C, 32'hFFFF_FFA5);
    rd("R11 oinit", 8'h5C, 32'hA5);
    wr(8'h14, 32'hFFFF_FFFF);
    rd("R11 ch1 ctrl", 8'h14, 32'h3C);
    wr(8'h18, 32'h0001_2345);
    rd("R11 ch1 thresh", 8'h18, 32'h2345);
    rd("R11 unmapped", 8'h90, 0);
    rd("R11 gap", 8'h50, 0);

    // R6 R7 R8 R9 directed configuration, limit 9
    wr(8'h08, 9);
    wr(8'h4C, 0);
    wr(8'h0C, 32'h28); wr(8'h10, 4);
    wr(8'h14, 32'h28); wr(8'h18, 0);
    wr(8'h1C, 32'h28); wr(8'h20, 12);
    wr(8'h24, 32'h00); wr(8'h28, 5);
    wr(8'h2C, 32'h28); wr(8'h30, 3);
    wr(8'h70, 32'h10);
    wr(8'h60, 32'h80);
    wr(8'h04, 0);
    ticks(1, 0, 0);
    wr(8'h00, 32'h08);
    repeat (30) step();

    // R10 buffering: limit change waits for the wrap
    ticks(0, 0, 0);
    wr(8'h04, 0);
    wr(8'h08, 3);
    ticks(1, 0, 0);
    repeat (5) step();
    rd("R10 old limit still active", 8'h04, 5);
    repeat (12) step();

    // R2 source selection
    wr(8'h08, 40);
    wr(8'h04, 0);
    wr(8'h00, 32'h10);
    ticks(1, 0, 1);
    repeat (5) step();
    held = m_cnt;
    rd("R2 wrong enable holds", 8'h04, 32'(held));
    ticks(0, 1, 0);
    repeat (3) step();
    rd("R2 fixed enable runs", 8'h04, 32'(held + 3));
    wr(8'h00, 32'h18);
    ticks(0, 0, 1);
    repeat (2) step();
    wr(8'h00, 32'h00);
    ticks(1, 1, 1);
    held = m_cnt;
    repeat (4) step();
    rd("R2 source off holds", 8'h04, 32'(held));

    // R3 prescale by 4, R5 count write
    wr(8'h4C, 2);
    ticks(0, 0, 0);
    wr(8'h04, 32'h77);
    rd("R5 count write loads start", 8'h04, 2);
    wr(8'h00, 32'h0A);
    ticks(1, 0, 0);
    repeat (8) step();
    rd("R3 prescale 4", 8'h04, 4);

    // constrained random phase
    for (int c = 0; c < 3000; c++) begin
      ticks(1'($urandom), 1'($urandom), 1'($urandom));
      if ($urandom % 12 == 0) begin
        int r, ch;
        r  = $urandom % 10;
        ch = $urandom % 8;
        case (r)
          0: wr(8'h00, (($urandom % 4 == 0) ? 0 : (($urandom % 3 + 1) << 3)) | ($urandom % 3));
          1: wr(8'h04, $urandom);
          2: wr(8'h08, $urandom % 40);
          3: wr(8'h4C, $urandom % 6);
          4, 5: wr(8'(12 + 8 * ch), ($urandom % 4 == 0) ? $urandom : 32'h28);
          6, 7: wr(8'(16 + 8 * ch), $urandom % 48);
          8: wr(8'h60, $urandom % 256);
          default: wr(8'h70, $urandom % 256);
        endcase
      end else begin
        step();
      end
    end
    summary();
  end

endmodule